// File: doc/BRIEF.md
# Subcode Q Block Validator and Host Serial Port

This block sits after subcode sync detection in a disc playback data path. For every frame it receives one Q-channel bit, together with a strobe, and a second strobe that marks the first frame of each 98-frame subcode block. The first two frames of a block carry the sync patterns. The next 96 frames each contribute one bit of a 96-bit Q payload. As the bits arrive, a bit-serial CRC-16 runs over the 80 data bits. The 16 check bits are complemented before they enter the same register, so a clean block leaves a zero remainder.

Only a block that passes the CRC reaches the host side. A block that passes goes into an output latch and raises a ready flag. The host microcontroller then pulls the 96 bits out by toggling a serial clock. The bits leave least significant first, which is also the order in which they arrived from the disc. If a new good block completes while the host is part way through a read, it waits in a holding buffer until the read ends. The output pins are shared with general-purpose outputs, and a select input decides which function drives them.

Top module: `subq_crc_port`

## Requirements
- R1: The frame strobe that comes together with the block-start strobe is frame 1. Frame 2 carries no payload. Frames 3 to 98 deliver payload bits 0 to 95 in that order. Frame strobes that arrive after frame 98 without a new block start deliver nothing. A block start in the middle of a block restarts the count at frame 1.
- R2: The CRC uses polynomial 0x1021 with an all-zero start value. Payload bits 0 to 79 are fed in arrival order, and bit 0 is the highest-order message bit. Payload bits 80 to 95 hold the bitwise complement of the 16-bit remainder, with bit 80 as the remainder's most significant bit. A block passes only when every one of these conditions holds.
- R3: A passing block is loaded into the output latch, and ready goes high on the second rising clock edge after the 98th frame strobe is sampled.
- R4: A failing block leaves ready unchanged and leaves the previously latched good block readable unchanged.
- R5: The serial data pin shows payload bit k after the host has given k rising edges of its serial clock since the read began. Bit 0 is therefore shown first.
- R6: Ready goes low once the host has given the 96th rising edge of a read, unless a held block is waiting.
- R7: A passing block that completes while a read is in progress (1 to 95 edges given) does not disturb that read. When the read ends, the held block is loaded and ready stays high.
- R8: When the select input is 1, pin 0 is serial data and pin 1 is ready. When it is 0, both pins copy the general-purpose output value bit for bit.
- R9: After a read ends, the host may clock the latched block out again and receives the same 96 bits.
- R10: After reset, ready is low and the serial data pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb_i | input | 1 | One-cycle pulse per subcode frame |
| blk_start_i | input | 1 | High with the frame strobe of frame 1 of a block |
| q_bit_i | input | 1 | Q-channel bit of the current frame |
| host_sclk_i | input | 1 | Host serial clock, asynchronous, rising edge advances the read |
| port_sel_i | input | 1 | 1 selects the subcode port on the pins, 0 selects general-purpose outputs |
| gpio_i | input | 2 | General-purpose output values |
| pin_o | output | 2 | Shared pins: bit 0 data, bit 1 ready when the port is selected |

## Verification
Ready is due two rising clock edges after the last frame strobe of a block is sampled. The bench drives each strobe on a falling edge and waits four cycles before it reads ready. A host clock edge passes through a two-flop synchronizer and an edge detector, so the data pin moves within three system clocks of the host's rising edge. The bench holds each host clock level for four cycles and reads the pin only after a full low phase. The pin multiplexer is purely combinational, so select and general-purpose changes are checked one falling edge after they are driven.

// File: rtl/sqs_pkg.sv
package sqs_pkg;
    localparam int unsigned QBITS_DEF  = 96;
    localparam int unsigned DBITS_DEF  = 80;
    localparam int unsigned FRAMES_DEF = 98;
    localparam int unsigned SYNCF_DEF  = 2;
    localparam int unsigned CRCW_DEF   = 16;
    localparam logic [15:0] POLY_DEF   = 16'h1021;
    localparam int unsigned SYNC_DEF   = 2;
    localparam int unsigned PIN_W      = 2;
    localparam int unsigned PIN_DATA   = 0;
    localparam int unsigned PIN_RDY    = 1;
endpackage

// File: rtl/sqs_crc_lfsr.sv
module sqs_crc_lfsr #(
    parameter int unsigned CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             din_i,
    output logic [CRC_W-1:0] rem_o
);
    typedef struct packed {
        logic [CRC_W-1:0] rem;
    } crc_st_t;

    crc_st_t s_d, s_q;
    logic    fb;

    always_comb begin
        s_d = s_q;
        fb  = din_i ^ s_q.rem[CRC_W-1];
        if (clr_i) begin
            s_d.rem = '0;
        end else if (en_i) begin
            s_d.rem = {s_q.rem[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rem_o = s_q.rem;

    // R2: a block start always begins from a zero remainder
    p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (rem_o == '0));
endmodule

// File: rtl/sqs_frame_collect.sv
module sqs_frame_collect #(
    parameter int unsigned QBITS  = 96,
    parameter int unsigned DBITS  = 80,
    parameter int unsigned FRAMES = 98,
    parameter int unsigned SYNCF  = 2,
    parameter int unsigned CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb_i,
    input  logic             blk_start_i,
    input  logic             q_bit_i,
    output logic             blk_done_o,
    output logic             blk_ok_o,
    output logic [QBITS-1:0] blk_data_o
);
    localparam int unsigned CNT_W   = $clog2(FRAMES + 1);
    localparam int unsigned IDX_W   = $clog2(QBITS);
    localparam int unsigned FIRST_Q = SYNCF + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [QBITS-1:0] data;
        logic             done;
    } col_st_t;

    col_st_t          s_d, s_q;
    logic             crc_clr, crc_en, crc_din;
    logic [IDX_W-1:0] idx;
    logic [CRC_W-1:0] rem;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        crc_din  = 1'b0;
        idx      = '0;
        if (frame_stb_i) begin
            if (blk_start_i) begin
                s_d.cnt = CNT_W'(1);
                crc_clr = 1'b1;
            end else if (s_q.cnt != '0 && s_q.cnt < CNT_W'(FRAMES)) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end else begin
                s_d.cnt = '0;
            end
            if (s_d.cnt >= CNT_W'(FIRST_Q)) begin
                idx           = IDX_W'(s_d.cnt - CNT_W'(FIRST_Q));
                s_d.data[idx] = q_bit_i;
                crc_en        = 1'b1;
                crc_din       = q_bit_i ^ (idx >= IDX_W'(DBITS));
                s_d.done      = (s_d.cnt == CNT_W'(FRAMES));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    sqs_crc_lfsr #(.CRC_W(CRC_W), .POLY(POLY)) crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (crc_clr),
        .en_i  (crc_en),
        .din_i (crc_din),
        .rem_o (rem)
    );

    assign blk_done_o = s_q.done;
    assign blk_ok_o   = (rem == '0);
    assign blk_data_o = s_q.data;

    // R1: completion is flagged only when the last frame of a block was counted
    p_done_last_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done_o |-> (s_q.cnt == CNT_W'(FRAMES)));
    // R1: the frame count never leaves its range
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(FRAMES));
endmodule

// File: rtl/sqs_host_port.sv
module sqs_host_port #(
    parameter int unsigned QBITS   = 96,
    parameter int unsigned SYNC_ST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             blk_done_i,
    input  logic             blk_ok_i,
    input  logic [QBITS-1:0] blk_data_i,
    output logic             ser_o,
    output logic             rdy_o
);
    localparam int unsigned IDX_W = $clog2(QBITS);

    typedef struct packed {
        logic [SYNC_ST-1:0] sync;
        logic               prev;
        logic [QBITS-1:0]   out;
        logic [QBITS-1:0]   pend;
        logic               pend_v;
        logic [IDX_W-1:0]   rd;
        logic               rdy;
    } hp_st_t;

    hp_st_t             s_d, s_q;
    logic [SYNC_ST-1:0] sync_nxt;
    logic               sclk_rise, rd_end, new_good;

    generate
        if (SYNC_ST == 1) begin : g_sync1
            assign sync_nxt = sclk_i;
        end else begin : g_syncn
            assign sync_nxt = {s_q.sync[SYNC_ST-2:0], sclk_i};
        end
    endgenerate

    assign sclk_rise = s_q.sync[SYNC_ST-1] & ~s_q.prev;
    assign rd_end    = sclk_rise && (s_q.rd == IDX_W'(QBITS - 1));
    assign new_good  = blk_done_i && blk_ok_i;

    always_comb begin
        s_d      = s_q;
        s_d.sync = sync_nxt;
        s_d.prev = s_q.sync[SYNC_ST-1];
        if (sclk_rise) begin
            s_d.rd = rd_end ? '0 : s_q.rd + 1'b1;
        end
        if (rd_end) begin
            s_d.rdy = 1'b0;
            if (s_q.pend_v) begin
                s_d.out    = s_q.pend;
                s_d.pend_v = 1'b0;
                s_d.rdy    = 1'b1;
            end
        end
        if (new_good) begin
            if (s_d.rd == '0) begin
                s_d.out    = blk_data_i;
                s_d.pend_v = 1'b0;
                s_d.rdy    = 1'b1;
            end else begin
                s_d.pend   = blk_data_i;
                s_d.pend_v = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ser_o = s_q.out[s_q.rd];
    assign rdy_o = s_q.rdy;

    p_good_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        new_good |=> rdy_o);
    p_bad_no_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done_i && !blk_ok_i && !s_q.pend_v) |=> !$rose(rdy_o));
    p_read_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rd < IDX_W'(QBITS));
    p_ready_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && !s_q.pend_v && !new_good) |=> !rdy_o);
    p_latch_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rd != '0 && s_q.rd != IDX_W'(QBITS - 1)) |=> $stable(s_q.out));
endmodule

// File: rtl/subq_crc_port.sv
module subq_crc_port
    import sqs_pkg::*;
#(
    parameter int unsigned QBITS   = QBITS_DEF,
    parameter int unsigned DBITS   = DBITS_DEF,
    parameter int unsigned FRAMES  = FRAMES_DEF,
    parameter int unsigned SYNCF   = SYNCF_DEF,
    parameter int unsigned CRC_W   = CRCW_DEF,
    parameter logic [CRC_W-1:0] POLY = POLY_DEF,
    parameter int unsigned SYNC_ST = SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb_i,
    input  logic             blk_start_i,
    input  logic             q_bit_i,
    input  logic             host_sclk_i,
    input  logic             port_sel_i,
    input  logic [PIN_W-1:0] gpio_i,
    output logic [PIN_W-1:0] pin_o
);
    logic             blk_done, blk_ok, ser, rdy;
    logic [QBITS-1:0] blk_data;
    logic [PIN_W-1:0] port_val;

    sqs_frame_collect #(
        .QBITS(QBITS), .DBITS(DBITS), .FRAMES(FRAMES),
        .SYNCF(SYNCF), .CRC_W(CRC_W), .POLY(POLY)
    ) col_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_stb_i (frame_stb_i),
        .blk_start_i (blk_start_i),
        .q_bit_i     (q_bit_i),
        .blk_done_o  (blk_done),
        .blk_ok_o    (blk_ok),
        .blk_data_o  (blk_data)
    );

    sqs_host_port #(.QBITS(QBITS), .SYNC_ST(SYNC_ST)) hp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (host_sclk_i),
        .blk_done_i (blk_done),
        .blk_ok_i   (blk_ok),
        .blk_data_i (blk_data),
        .ser_o      (ser),
        .rdy_o      (rdy)
    );

    always_comb begin
        port_val           = '0;
        port_val[PIN_DATA] = ser;
        port_val[PIN_RDY]  = rdy;
        pin_o              = port_sel_i ? port_val : gpio_i;
    end

    // R10: nothing is ready in the first cycle after reset
    p_reset_idle_r10: assert property (@(posedge clk)
        $rose(rst_n) |-> !rdy);
endmodule

// File: tb/subq_crc_port_tb_top.sv
module subq_crc_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0, blk_start = 1'b0, q_bit = 1'b0;
    logic       sclk = 1'b0, sel = 1'b1;
    logic [1:0] gpio = 2'b00;
    logic [1:0] pin;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    subq_crc_port dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_stb_i (frame_stb),
        .blk_start_i (blk_start),
        .q_bit_i     (q_bit),
        .host_sclk_i (sclk),
        .port_sel_i  (sel),
        .gpio_i      (gpio),
        .pin_o       (pin)
    );

    // {flip index (127 = none), expected ready, 80 data bits}
    localparam logic [87:0] VEC [4] = '{
        {7'd127, 1'b1, 80'h0123_4567_89AB_CDEF_1357},
        {7'd5,   1'b0, 80'hFEDC_BA98_7654_3210_2468},
        {7'd127, 1'b1, 80'hA5A5_5A5A_F00F_0FF0_C33C},
        {7'd90,  1'b0, 80'h1111_2222_3333_4444_5555}
    };

    logic [95:0] last_good, blk_a, blk_b, tmp;
    logic [87:0] ent;

    function automatic logic [95:0] make_block(input logic [79:0] d);
        logic [15:0] c = 16'h0000;
        logic        fb;
        logic [95:0] b;
        for (int i = 0; i < 80; i++) begin
            fb = d[i] ^ c[15];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        b[79:0] = d;
        for (int j = 0; j < 16; j++) b[80 + j] = ~c[15 - j];
        return b;
    endfunction

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input logic st, input logic b);
        @(negedge clk);
        frame_stb = 1'b1; blk_start = st; q_bit = b;
        @(negedge clk);
        frame_stb = 1'b0; blk_start = 1'b0; q_bit = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_block(input logic [95:0] b, input logic st);
        send_frame(st, 1'b0);
        send_frame(1'b0, 1'b1);
        for (int i = 0; i < 96; i++) send_frame(1'b0, b[i]);
        repeat (4) @(negedge clk);
    endtask

    task automatic host_pulse();
        @(negedge clk); sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_bits(input string tag, input logic [95:0] exp, input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            chk(tag, {95'b0, pin[0]}, {95'b0, exp[i]});
            host_pulse();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 ready after reset", {95'b0, pin[1]}, 96'd0);
        chk("R10 data after reset", {95'b0, pin[0]}, 96'd0);
        // R8: general-purpose path
        sel = 1'b0; gpio = 2'b10; @(negedge clk);
        chk("R8 gpio 10", {94'b0, pin}, {94'b0, 2'b10});
        gpio = 2'b01; @(negedge clk);
        chk("R8 gpio 01", {94'b0, pin}, {94'b0, 2'b01});
        sel = 1'b1; @(negedge clk);
        chk("R8 port selected", {94'b0, pin}, 96'd0);

        last_good = '0;
        // table: R2 R3 R4 R5 R6 R9
        for (int v = 0; v < 4; v++) begin
            ent = VEC[v];
            tmp = make_block(ent[79:0]);
            if (ent[87:81] != 7'd127) tmp[ent[87:81]] = ~tmp[ent[87:81]];
            send_block(tmp, 1'b1);
            chk("R3/R4 ready after block", {95'b0, pin[1]}, {95'b0, ent[80]});
            if (ent[80]) last_good = tmp;
            // R5 LSB first; R4/R9 failed block rereads last good
            read_bits("R5 R4 R9 serial bit", last_good, 0, 96);
            chk("R6 ready after 96 edges", {95'b0, pin[1]}, 96'd0);
        end

        // R9: reread once more gives same block
        read_bits("R9 reread", last_good, 0, 96);

        // R1: frames without block start deliver nothing
        send_block(make_block(80'hDEAD_BEEF_0000_FFFF_1234), 1'b0);
        chk("R1 no start no ready", {95'b0, pin[1]}, 96'd0);
        read_bits("R1 latch unchanged", last_good, 0, 8);
        read_bits("R1 latch unchanged", last_good, 8, 96);

        // R1: restart mid-block
        tmp = make_block(80'h0F0F_0F0F_0F0F_0F0F_0F0F);
        send_frame(1'b1, 1'b0);
        send_frame(1'b0, 1'b1);
        for (int i = 0; i < 40; i++) send_frame(1'b0, ~tmp[i]);
        send_block(tmp, 1'b1);
        chk("R1 restart ready", {95'b0, pin[1]}, 96'd1);
        read_bits("R1 restart data", tmp, 0, 96);

        // R7: good block during a read is held
        blk_a = make_block(80'h1234_5678_9ABC_DEF0_1111);
        blk_b = make_block(80'h8888_7777_6666_5555_4444);
        send_block(blk_a, 1'b1);
        read_bits("R7 first part", blk_a, 0, 10);
        send_block(blk_b, 1'b1);
        chk("R7 ready during read", {95'b0, pin[1]}, 96'd1);
        read_bits("R7 read undisturbed", blk_a, 10, 96);
        chk("R7 ready after held load", {95'b0, pin[1]}, 96'd1);
        read_bits("R7 held block", blk_b, 0, 96);
        chk("R6 ready low after held read", {95'b0, pin[1]}, 96'd0);

        // R8: gpio again while port holds a block
        sel = 1'b0; gpio = 2'b11; @(negedge clk);
        chk("R8 gpio 11", {94'b0, pin}, {94'b0, 2'b11});
        sel = 1'b1; @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule